// File: doc/BRIEF.md
# Over-Temperature Shutdown and Interrupt Controller

This block follows the die temperature through three states: normal, warning and shutdown. Each time the sensing front end presents a new temperature code, the block compares it against a warning threshold and a shutdown threshold. Both thresholds use one shared hysteresis value. While the die is in shutdown, the block forces every current source and sink switch open. It does not touch the configuration inputs or the last recorded switch pattern.

Entry to shutdown and exit from shutdown both latch an interrupt bit and pull an active-low interrupt line. The host clears the latched bits by reading the status register during a chip-select low window. The clear takes effect on the chip-select rising edge that follows. Live status bits and a temperature flag are provided for the serial status field.

When shutdown ends, the block sends a one-cycle restart pulse to the polling sequencer. The next completed polling cycle always raises a switch-change interrupt, and the switch pattern sensed in that cycle becomes the new reference.

Top module: `thermal_guard`

## Requirements
- R1: After reset the block is in normal: int_n=1, int_stat=0, st_tw=0, st_tsd=0, temp_flag=0, poll_restart=0, sw_ref=0.
- R2: On a temp_vld strobe in normal with temp_code > warn_thr, the block moves to warning. This holds even when the code is also above shut_thr, so shutdown is never entered straight from normal. On a strobe in warning with temp_code < warn_thr - hyst, it returns to normal. Codes between those two levels keep the warning state.
- R3: On a strobe in warning with temp_code > shut_thr, the block enters shutdown. While in shutdown, sw_en is all zeros. Outside shutdown, sw_en equals sw_req.
- R4: On entry to shutdown, int_stat bit 0 (thermal bit) is set and int_n goes low.
- R5: st_tsd is 1 exactly while in shutdown. st_tw is 1 in both warning and shutdown. temp_flag is 1 in any state other than normal.
- R6: Shutdown is held until a strobe with temp_code < shut_thr - hyst arrives. The block then goes to warning if temp_code >= warn_thr - hyst, and to normal otherwise. In both cases int_stat bit 0 is set again and int_n goes low.
- R7: int_stat is cleared and int_n released on a cs_n rising edge, but only if stat_rd was high during that cs_n low window. A low window with no read leaves int_stat unchanged. Staying in shutdown after a clear raises no new interrupt.
- R8: On shutdown exit, poll_restart is high for exactly one cycle.
- R9: The first poll_cycle_end after a shutdown exit sets int_stat bit 1 (switch-change bit) even when sw_sense equals sw_ref.
- R10: Outside shutdown, every poll_cycle_end loads sw_sense into sw_ref, and it sets int_stat bit 1 when sw_sense differs from the old sw_ref. During shutdown, poll_cycle_end is ignored and sw_ref holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warn_thr | input | TW | Warning threshold code |
| shut_thr | input | TW | Shutdown threshold code |
| hyst | input | TW | Hysteresis shared by both thresholds |
| temp_vld | input | 1 | Strobe: temp_code holds a new sample |
| temp_code | input | TW | Sampled temperature code |
| sw_req | input | NSW | Switch closures requested by configuration |
| sw_sense | input | NSW | Switch pattern sensed in the finished polling cycle |
| poll_cycle_end | input | 1 | Strobe: a polling cycle has completed |
| cs_n | input | 1 | Serial chip-select, active low |
| stat_rd | input | 1 | Strobe: interrupt status register is being read |
| sw_en | output | NSW | Switch closure enables after thermal gating |
| poll_restart | output | 1 | One-cycle pulse that restarts polling |
| sw_ref | output | NSW | Reference switch pattern |
| int_n | output | 1 | Active-low interrupt |
| int_stat | output | 2 | Latched interrupt bits: bit 0 thermal, bit 1 switch change |
| st_tw | output | 1 | Live warning status |
| st_tsd | output | 1 | Live shutdown status |
| temp_flag | output | 1 | Over-temperature flag for the serial status field |

## Verification
Every result is registered once. A temperature strobe, a poll_cycle_end or a cs_n rising edge presented before a rising clock edge therefore shows on the outputs right after that edge. The bench drives inputs on falling edges. It samples the outputs on the next falling edge, which is the single point where the new value is due. For the clear path, the read strobe and the chip-select rise sit in separate cycles, and the check comes one cycle after the rise. The restart pulse is checked high at its due point and low one cycle later.

// File: rtl/thermal_guard.sv
module thermal_guard #(
  parameter int TW  = 8,
  parameter int NSW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  warn_thr,
  input  logic [TW-1:0]  shut_thr,
  input  logic [TW-1:0]  hyst,
  input  logic           temp_vld,
  input  logic [TW-1:0]  temp_code,
  input  logic [NSW-1:0] sw_req,
  input  logic [NSW-1:0] sw_sense,
  input  logic           poll_cycle_end,
  input  logic           cs_n,
  input  logic           stat_rd,
  output logic [NSW-1:0] sw_en,
  output logic           poll_restart,
  output logic [NSW-1:0] sw_ref,
  output logic           int_n,
  output logic [1:0]     int_stat,
  output logic           st_tw,
  output logic           st_tsd,
  output logic           temp_flag
);

  typedef enum logic [1:0] {S_NORM = 2'd0, S_WARN = 2'd1, S_SHUT = 2'd2} tstate_e;

  tstate_e state, state_nx;
  logic [TW-1:0] warn_lo, shut_lo;
  logic cs_q, rd_seen, clr, enter_shut, leave_shut, first_cyc, poll_ok, ssc_set;

  assign warn_lo = (warn_thr > hyst) ? warn_thr - hyst : '0;
  assign shut_lo = (shut_thr > hyst) ? shut_thr - hyst : '0;

  always_comb begin
    state_nx = state;
    if (temp_vld) begin
      case (state)
        S_NORM:  if (temp_code > warn_thr) state_nx = S_WARN;
        S_WARN:  if (temp_code > shut_thr) state_nx = S_SHUT;
                 else if (temp_code < warn_lo) state_nx = S_NORM;
        S_SHUT:  if (temp_code < shut_lo)
                   state_nx = (temp_code < warn_lo) ? S_NORM : S_WARN;
        default: state_nx = S_NORM;
      endcase
    end
  end

  assign enter_shut = (state != S_SHUT) && (state_nx == S_SHUT);
  assign leave_shut = (state == S_SHUT) && (state_nx != S_SHUT);
  assign clr        = cs_n && !cs_q && rd_seen;
  assign poll_ok    = poll_cycle_end && (state != S_SHUT);
  assign ssc_set    = poll_ok && (first_cyc || (sw_sense != sw_ref));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_NORM;
      cs_q         <= 1'b1;
      rd_seen      <= 1'b0;
      int_stat     <= '0;
      poll_restart <= 1'b0;
      first_cyc    <= 1'b0;
      sw_ref       <= '0;
    end else begin
      state        <= state_nx;
      cs_q         <= cs_n;
      poll_restart <= leave_shut;
      if (cs_n && !cs_q)       rd_seen <= 1'b0;
      else if (!cs_n && stat_rd) rd_seen <= 1'b1;
      int_stat[0] <= (int_stat[0] && !clr) || enter_shut || leave_shut;
      int_stat[1] <= (int_stat[1] && !clr) || ssc_set;
      if (leave_shut)   first_cyc <= 1'b1;
      else if (poll_ok) first_cyc <= 1'b0;
      if (poll_ok) sw_ref <= sw_sense;
    end
  end

  assign st_tsd    = (state == S_SHUT);
  assign st_tw     = (state != S_NORM);
  assign temp_flag = (state != S_NORM);
  assign sw_en     = st_tsd ? '0 : sw_req;
  assign int_n     = ~|int_stat;

  a_r2_shut_from_warn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_tsd) |-> $past(st_tw));
  a_r3_switches_open: assert property (@(posedge clk) disable iff (!rst_n)
    st_tsd |-> (sw_en == '0));
  a_r4_entry_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_tsd) |-> (!int_n && int_stat[0]));
  a_r5_tw_with_tsd: assert property (@(posedge clk) disable iff (!rst_n)
    st_tsd |-> (st_tw && temp_flag));
  a_r6_exit_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_tsd) |-> (!int_n && int_stat[0]));
  a_r7_clear_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(int_stat) != 2'b00) && (int_stat == 2'b00)) |-> ($past(cs_n) && !$past(cs_q)));
  a_r8_restart_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_tsd) |-> poll_restart);
  a_r8_restart_single: assert property (@(posedge clk) disable iff (!rst_n)
    poll_restart |=> !poll_restart);
  a_r10_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_tsd && $past(st_tsd)) |-> $stable(sw_ref));

endmodule

// File: tb/thermal_guard_tb.sv
module thermal_guard_tb_top;
  localparam int TW = 8, NSW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TW-1:0] warn_thr = 8'd100, shut_thr = 8'd150, hyst = 8'd10, temp_code = '0;
  logic temp_vld = 0, poll_cycle_end = 0, cs_n = 1, stat_rd = 0;
  logic [NSW-1:0] sw_req = 8'hA5, sw_sense = '0;
  logic [NSW-1:0] sw_en, sw_ref;
  logic poll_restart, int_n, st_tw, st_tsd, temp_flag;
  logic [1:0] int_stat;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  thermal_guard #(.TW(TW), .NSW(NSW)) dut_i (
    .clk(clk), .rst_n(rst_n), .warn_thr(warn_thr), .shut_thr(shut_thr), .hyst(hyst),
    .temp_vld(temp_vld), .temp_code(temp_code), .sw_req(sw_req), .sw_sense(sw_sense),
    .poll_cycle_end(poll_cycle_end), .cs_n(cs_n), .stat_rd(stat_rd), .sw_en(sw_en),
    .poll_restart(poll_restart), .sw_ref(sw_ref), .int_n(int_n), .int_stat(int_stat),
    .st_tw(st_tw), .st_tsd(st_tsd), .temp_flag(temp_flag));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sample(logic [TW-1:0] c);
    temp_code = c; temp_vld = 1;
    @(negedge clk); temp_vld = 0;
  endtask

  task automatic poll(logic [NSW-1:0] s);
    sw_sense = s; poll_cycle_end = 1;
    @(negedge clk); poll_cycle_end = 0;
  endtask

  task automatic cs_window(bit do_read);
    cs_n = 0; stat_rd = do_read;
    @(negedge clk); stat_rd = 0;
    @(negedge clk); cs_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 int_n", int_n, 1); chk("R1 int_stat", int_stat, 0);
    chk("R1 st_tw", st_tw, 0); chk("R1 st_tsd", st_tsd, 0);
    chk("R1 temp_flag", temp_flag, 0); chk("R1 poll_restart", poll_restart, 0);
    chk("R1 sw_ref", sw_ref, 0); chk("R3 sw_en normal", sw_en, 8'hA5);
  endtask

  task automatic t_poll_normal;
    poll(8'h11);
    chk("R10 ssc on change", int_stat, 2'b10); chk("R10 ref load", sw_ref, 8'h11);
    cs_window(1);
    chk("R7 cleared", int_stat, 0); chk("R7 int_n released", int_n, 1);
    poll(8'h11);
    chk("R10 no ssc when same", int_stat, 0);
  endtask

  task automatic t_warn;
    sample(8'd101);
    chk("R2 enter warn", st_tw, 1); chk("R5 flag warn", temp_flag, 1); chk("R5 tsd warn", st_tsd, 0);
    sample(8'd95);
    chk("R2 hold warn", st_tw, 1);
    sample(8'd89);
    chk("R2 back normal", st_tw, 0); chk("R5 flag normal", temp_flag, 0);
    sample(8'd200);
    chk("R2 normal only to warn tw", st_tw, 1); chk("R2 normal only to warn tsd", st_tsd, 0);
  endtask

  task automatic t_shut_entry;
    sample(8'd151);
    chk("R3 tsd", st_tsd, 1); chk("R3 switches open", sw_en, 0);
    chk("R4 int_stat", int_stat, 2'b01); chk("R4 int_n", int_n, 0);
    chk("R5 tw in shut", st_tw, 1); chk("R5 flag in shut", temp_flag, 1);
  endtask

  task automatic t_clear_in_shut;
    cs_window(0);
    chk("R7 no read no clear", int_stat, 2'b01);
    cs_window(1);
    chk("R7 clear", int_stat, 0); chk("R7 release", int_n, 1);
    sample(8'd145);
    chk("R6 hold shut", st_tsd, 1); chk("R7 no new irq", int_n, 1);
    sample(8'd140);
    chk("R6 hold at exit level", st_tsd, 1);
    poll(8'h22);
    chk("R10 ref held in shut", sw_ref, 8'h11); chk("R10 no ssc in shut", int_stat, 0);
  endtask

  task automatic t_exit_warn;
    sample(8'd139);
    chk("R6 left shut", st_tsd, 0); chk("R6 to warn", st_tw, 1);
    chk("R6 irq", int_stat, 2'b01); chk("R6 int_n", int_n, 0);
    chk("R8 restart high", poll_restart, 1); chk("R3 switches back", sw_en, 8'hA5);
    @(negedge clk);
    chk("R8 restart one cycle", poll_restart, 0);
    poll(8'h11);
    chk("R9 ssc on first cycle", int_stat, 2'b11); chk("R9 ref", sw_ref, 8'h11);
    cs_window(1);
    poll(8'h11);
    chk("R9 only first cycle", int_stat, 0);
  endtask

  task automatic t_exit_normal;
    sample(8'd151);
    chk("R3 reenter", st_tsd, 1);
    cs_window(1);
    sample(8'd50);
    chk("R6 straight to normal tw", st_tw, 0); chk("R6 straight to normal tsd", st_tsd, 0);
    chk("R6 irq again", int_stat, 2'b01);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_poll_normal;
    t_warn;
    t_shut_entry;
    t_clear_in_shut;
    t_exit_warn;
    t_exit_normal;
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule